// File: doc/BRIEF.md
# Masked Multi-Cycle Vector Integer Unit

The unit runs one integer vector instruction over a logical vector of 64 elements of 32 bits using only 16 identical ALU lanes. After it accepts an instruction, it walks through the vector in four consecutive groups of 16 elements, lowest group first. For each group it fetches the operands from an external register-file read port, applies the one operation to every lane, and presents the results with a per-element write enable. Decode happens once, at acceptance. The opcode and the 64-bit execution mask are held for all four groups.

The execution mask lets divergent control flow share one instruction stream. An element whose mask bit is clear gets no write enable, so its destination keeps its old value. The unit drops its ready signal while a vector is in flight. It raises ready again in the last group cycle, so a following instruction can start with no idle cycle between them. A one-cycle done pulse comes out together with the final group's writeback.

Top module: `simd_vec_unit`

## Requirements
- R1: While reset is held and right after it is released, `inst_ready_o` is 1, `wr_en_o` is all zero and `done_o` is 0.
- R2: Opcode 0 writes a+b and opcode 1 writes a-b, both wrapping modulo 2^32.
- R3: Opcode 2 writes a&b, opcode 3 writes a|b and opcode 4 writes a^b. Opcode 7 is unused and writes 0 on enabled elements.
- R4: Opcode 5 writes the signed minimum of a and b, and opcode 6 writes the signed maximum.
- R5: An instruction is accepted at a rising edge. In the k-th cycle after that edge (k = 0..3), `rd_grp_o` equals k and the lanes work on elements 16k..16k+15, with lane j handling element 16k+j. The results for group k appear on the write outputs one cycle later, with `wr_grp_o` equal to k.
- R6: In the writeback of group k, `wr_en_o[j]` equals mask bit 16k+j. An all-zero mask still takes the full four groups and produces no write enable.
- R7: `inst_ready_o` is 0 in processing cycles 0 to 2 and 1 in cycle 3. An instruction presented in cycle 3 is accepted, and its group 0 starts in the next cycle.
- R8: `done_o` pulses high exactly once per instruction, in the cycle in which group 3 is written.
- R9: An instruction presented while `inst_ready_o` is 0 is ignored. The opcode and mask of the instruction in flight stay in effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_valid_i | input | 1 | Instruction offered |
| inst_ready_o | output | 1 | Unit can accept an instruction this cycle |
| inst_op_i | input | 3 | Opcode |
| inst_mask_i | input | 64 | Per-element execution mask, bit e for element e |
| rd_grp_o | output | 2 | Element group being read from the register file |
| src_a_i | input | 512 | First operand group, lane j in bits 32j+31:32j |
| src_b_i | input | 512 | Second operand group, same layout |
| wr_grp_o | output | 2 | Element group being written |
| wr_en_o | output | 16 | Per-lane write enable |
| wr_data_o | output | 512 | Result group, lane j in bits 32j+31:32j |
| done_o | output | 1 | Final group of an instruction is being written |

## Verification
On every cycle, the assertions check the following. The group counter steps by one inside an instruction and restarts at zero on acceptance. Done appears only together with the last group's writeback and never in two cycles in a row. The signed minimum and maximum results never fall outside the bounds set by their operands. The bench scenarios are needed for the rest: the arithmetic values of each opcode on wrap and sign corners, the exact mapping of mask bits to write enables, the ready timing and back-to-back acceptance, and an instruction offered while busy being ignored.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_MIN  = 3'd5,
    OP_MAX  = 3'd6,
    OP_NONE = 3'd7
  } simd_op_e;
endpackage

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_pkg::*;
#(
  parameter int DW = 32
) (
  input  simd_op_e        op_i,
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [DW-1:0]   res_o
);
  logic a_lt_b;
  assign a_lt_b = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (op_i)
      OP_ADD:  res_o = a_i + b_i;
      OP_SUB:  res_o = a_i - b_i;
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_MIN:  res_o = a_lt_b ? a_i : b_i;
      OP_MAX:  res_o = a_lt_b ? b_i : a_i;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/simd_seq.sv
module simd_seq #(
  parameter int GROUPS = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  output logic          ready_o,
  output logic          accept_o,
  output logic          active_o,
  output logic          last_o,
  output logic [GW-1:0] grp_o
);
  localparam logic [GW-1:0] LAST_GRP = GW'(GROUPS - 1);

  logic          active_q;
  logic [GW-1:0] grp_q;

  assign last_o   = active_q && (grp_q == LAST_GRP);
  assign ready_o  = !active_q || last_o;
  assign accept_o = valid_i && ready_o;
  assign active_o = active_q;
  assign grp_o    = grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      grp_q    <= '0;
    end else if (accept_o) begin
      active_q <= 1'b1;
      grp_q    <= '0;
    end else if (last_o) begin
      active_q <= 1'b0;
      grp_q    <= '0;
    end else if (active_q) begin
      grp_q    <= grp_q + 1'b1;
    end
  end

  // R5: groups advance one per cycle inside an instruction
  a_r5_grp_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && grp_q != LAST_GRP) |=> (active_q && grp_q == $past(grp_q) + 1'b1));

  // R7: acceptance restarts at group 0
  a_r7_accept_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (active_q && grp_q == '0));

  // R9: an offer while busy leaves the sequence untouched
  a_r9_busy_offer_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && active_q && grp_q != LAST_GRP) |=> (grp_q != '0));
endmodule

// File: rtl/simd_wb.sv
module simd_wb #(
  parameter int LANES  = 16,
  parameter int DW     = 32,
  parameter int GROUPS = 4,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                act_i,
  input  logic                last_i,
  input  logic [GW-1:0]       grp_i,
  input  logic [LANES-1:0]    en_i,
  input  logic [LANES*DW-1:0] res_i,
  output logic [GW-1:0]       wr_grp_o,
  output logic [LANES-1:0]    wr_en_o,
  output logic [LANES*DW-1:0] wr_data_o,
  output logic                done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_grp_o  <= '0;
      wr_en_o   <= '0;
      wr_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      wr_en_o <= act_i ? en_i : '0;
      done_o  <= last_i;
      if (act_i) begin
        wr_grp_o  <= grp_i;
        wr_data_o <= res_i;
      end
    end
  end

  // R8: done only with the final group
  a_r8_done_on_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (wr_grp_o == GW'(GROUPS - 1)));

  // R8: never two done cycles in a row
  a_r8_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/simd_vec_unit.sv
module simd_vec_unit
  import simd_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int GROUPS = 4,
  parameter int DW     = 32,
  localparam int VLEN  = LANES * GROUPS,
  localparam int GW    = (GROUPS > 1) ? $clog2(GROUPS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inst_valid_i,
  output logic                inst_ready_o,
  input  logic [2:0]          inst_op_i,
  input  logic [VLEN-1:0]     inst_mask_i,
  output logic [GW-1:0]       rd_grp_o,
  input  logic [LANES*DW-1:0] src_a_i,
  input  logic [LANES*DW-1:0] src_b_i,
  output logic [GW-1:0]       wr_grp_o,
  output logic [LANES-1:0]    wr_en_o,
  output logic [LANES*DW-1:0] wr_data_o,
  output logic                done_o
);
  logic          accept, active, last;
  logic [GW-1:0] grp;
  simd_op_e      op_q;
  logic [VLEN-1:0] mask_q;
  logic [LANES-1:0] mask_slice [GROUPS];
  logic [LANES-1:0] grp_en;
  logic [LANES*DW-1:0] lane_res;

  simd_seq #(.GROUPS(GROUPS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (inst_valid_i),
    .ready_o (inst_ready_o),
    .accept_o(accept),
    .active_o(active),
    .last_o  (last),
    .grp_o   (grp)
  );

  // decode once per instruction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_NONE;
      mask_q <= '0;
    end else if (accept) begin
      op_q   <= simd_op_e'(inst_op_i);
      mask_q <= inst_mask_i;
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_slice
    assign mask_slice[g] = mask_q[g*LANES +: LANES];
  end

  assign grp_en   = mask_slice[grp];
  assign rd_grp_o = grp;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DW-1:0] a, b, r;
    assign a = src_a_i[l*DW +: DW];
    assign b = src_b_i[l*DW +: DW];

    simd_lane_alu #(.DW(DW)) u_alu (
      .op_i (op_q),
      .a_i  (a),
      .b_i  (b),
      .res_o(r)
    );
    assign lane_res[l*DW +: DW] = r;

    // R4: min/max results stay inside operand bounds
    a_r4_min_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && op_q == OP_MIN) |-> ($signed(r) <= $signed(a) && $signed(r) <= $signed(b)));
    a_r4_max_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (active && op_q == OP_MAX) |-> ($signed(r) >= $signed(a) && $signed(r) >= $signed(b)));
  end

  simd_wb #(.LANES(LANES), .DW(DW), .GROUPS(GROUPS)) u_wb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .act_i    (active),
    .last_i   (last),
    .grp_i    (grp),
    .en_i     (grp_en),
    .res_i    (lane_res),
    .wr_grp_o (wr_grp_o),
    .wr_en_o  (wr_en_o),
    .wr_data_o(wr_data_o),
    .done_o   (done_o)
  );
endmodule

// File: tb/simd_vec_unit_test.sv
`timescale 1ns/1ps
module simd_vec_unit_test;
  localparam int LANES = 16;
  localparam int GROUPS = 4;
  localparam int DW = 32;
  localparam int VLEN = LANES * GROUPS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inst_valid = 1'b0;
  logic inst_ready;
  logic [2:0] inst_op = '0;
  logic [VLEN-1:0] inst_mask = '0;
  logic [1:0] rd_grp;
  logic [LANES*DW-1:0] src_a, src_b;
  logic [1:0] wr_grp;
  logic [LANES-1:0] wr_en;
  logic [LANES*DW-1:0] wr_data;
  logic done;

  logic [DW-1:0] ra [VLEN];
  logic [DW-1:0] rb [VLEN];

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  simd_vec_unit uut (
    .clk_i(clk), .rst_ni(rst_n),
    .inst_valid_i(inst_valid), .inst_ready_o(inst_ready),
    .inst_op_i(inst_op), .inst_mask_i(inst_mask),
    .rd_grp_o(rd_grp), .src_a_i(src_a), .src_b_i(src_b),
    .wr_grp_o(wr_grp), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .done_o(done)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_rf
    assign src_a[j*DW +: DW] = ra[int'(rd_grp)*LANES + j];
    assign src_b[j*DW +: DW] = rb[int'(rd_grp)*LANES + j];
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(int op, logic [DW-1:0] a, logic [DW-1:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a & b;
      3: return a | b;
      4: return a ^ b;
      5: return ($signed(a) < $signed(b)) ? a : b;
      6: return ($signed(a) < $signed(b)) ? b : a;
      default: return '0;
    endcase
  endfunction

  function automatic string req_of(int op);
    if (op <= 1) return "R2";
    if (op <= 4 || op == 7) return "R3";
    return "R4";
  endfunction

  task automatic fill(int s);
    for (int i = 0; i < VLEN; i++) begin
      ra[i] = (i * 32'h9E3779B1 + s * 32'h01000193) ^ (s << 7);
      rb[i] = (i * 32'h85EBCA77 + s * 32'h27D4EB2F) ^ 32'h5A5A0000;
    end
    ra[0]  = 32'hFFFF_FFFF; rb[0]  = 32'h0000_0001;
    ra[17] = 32'h0000_0000; rb[17] = 32'h0000_0001;
    ra[34] = 32'h8000_0000; rb[34] = 32'h7FFF_FFFF;
    ra[51] = 32'hFFFF_FFFE; rb[51] = 32'h0000_0003;
    ra[63] = 32'h7FFF_FFFF; rb[63] = 32'h7FFF_FFFF;
  endtask

  // Checks one instruction, the accept edge being just behind.
  task automatic follow(int op, logic [VLEN-1:0] mask, bit fresh,
                        bit chain, int op2, logic [VLEN-1:0] mask2, bit glitch);
    for (int k = 0; k <= 4; k++) begin
      if (k > 0 || fresh) @(negedge clk);
      if (k == 0 && fresh) inst_valid = 1'b0;
      if (k < 4) begin
        chk("R5 rd_grp", 64'(rd_grp), 64'(k));
        chk("R7 ready", 64'(inst_ready), 64'(k == 3));
      end
      if (glitch && k == 1) begin
        inst_valid = 1'b1; inst_op = 3'(op ^ 1); inst_mask = ~mask;
      end
      if (glitch && k == 2) inst_valid = 1'b0;
      if (chain && k == 3) begin
        inst_valid = 1'b1; inst_op = 3'(op2); inst_mask = mask2;
      end
      if (k >= 1) begin
        int g = k - 1;
        chk("R5 wr_grp", 64'(wr_grp), 64'(g));
        chk("R8 done", 64'(done), 64'(k == 4));
        for (int j = 0; j < LANES; j++) begin
          int e = g * LANES + j;
          chk(glitch ? "R9 wr_en" : "R6 wr_en", 64'(wr_en[j]), 64'(mask[e]));
          if (mask[e])
            chk(glitch ? "R9 data" : req_of(op), 64'(wr_data[j*DW +: DW]),
                64'(model(op, ra[e], rb[e])));
        end
      end else if (fresh) begin
        chk("R8 no done before", 64'(done), 64'd0);
        chk("R6 no write before", 64'(wr_en), 64'd0);
      end
      if (k == 4) begin
        if (chain) begin
          inst_valid = 1'b0;
          chk("R7 back-to-back busy", 64'(inst_ready), 64'd0);
          chk("R7 back-to-back grp", 64'(rd_grp), 64'd0);
        end else begin
          chk("R7 ready after", 64'(inst_ready), 64'd1);
        end
      end
    end
  endtask

  task automatic issue(int op, logic [VLEN-1:0] mask, bit glitch);
    @(negedge clk);
    inst_valid = 1'b1; inst_op = 3'(op); inst_mask = mask;
    follow(op, mask, 1'b1, 1'b0, 0, '0, glitch);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [VLEN-1:0] masks [5];
    masks[0] = '1;
    masks[1] = '0;
    masks[2] = 64'hAAAA_5555_F0F0_0F0F;
    masks[3] = 64'h0123_4567_89AB_CDEF;
    masks[4] = 64'h8000_0000_0000_0001;
    fill(1);
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", 64'(inst_ready), 64'd1);
    chk("R1 done in reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", 64'(inst_ready), 64'd1);
    chk("R1 wr_en", 64'(wr_en), 64'd0);
    chk("R1 done", 64'(done), 64'd0);

    for (int s = 1; s <= 2; s++) begin
      fill(s);
      for (int op = 0; op < 8; op++)
        for (int m = 0; m < 5; m++)
          issue(op, masks[m], 1'b0);
    end

    // R9: offer while busy is ignored
    issue(0, masks[2], 1'b1);
    issue(5, masks[0], 1'b1);

    // R7: back-to-back acceptance
    @(negedge clk);
    inst_valid = 1'b1; inst_op = 3'd1; inst_mask = masks[3];
    follow(1, masks[3], 1'b1, 1'b1, 6, masks[2], 1'b0);
    follow(6, masks[2], 1'b0, 1'b1, 4, masks[1], 1'b0);
    follow(4, masks[1], 1'b0, 1'b0, 0, '0, 1'b0);

    @(negedge clk);
    chk("R8 single pulse", 64'(done), 64'd0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule